// File: doc/BRIEF.md
# Two-Key Write Protection Gate

This block sits on the write path of a byte-wide configuration register file and decides, per write, whether the write may land. The register file is divided into four protectable groups: working, control, slot timing and sequence mapping. Two 8-bit key registers share one bit layout, with one bit per group. A group is locked only while its bit is 1 in both key registers. Requiring the same bit in two separately written registers means one stray write cannot lock a group.

Key bits can only be set. A host write is merged into a key register as old value OR new data, and the reserved positions are masked off. Only the power-on reset returns a key bit to 0. Writes to a locked group are dropped without any error. A one-cycle `wr_accepted` flag reports each write's outcome. Reads are never gated. For testing, a small stub register file stands in for the real registers below address 0x40.

Top module: `cfg_wr_guard`

## Requirements
- R1: After power-on reset, both key registers (0xF0, 0xF1), every stub register and `wr_accepted` read 0.
- R2: A write to 0xF0 or 0xF1 sets the key register to old OR (data AND 0x59). Only bits 6, 4, 3 and 0 are implemented, and the reserved bits always read 0.
- R3: A key bit that is 1 stays 1 for any host write, including writing 0. Only reset clears it.
- R4: A group is locked only when its key bit is 1 in both key registers. With the bit set in one register only, writes to the group still land.
- R5: A write to a locked group leaves the addressed register unchanged and produces `wr_accepted` = 0.
- R6: Group decode: addresses 0x10–0x1F map to the working group (bit 6), 0x25, 0x28, 0x29 and 0x2B map to the control group (bit 0), 0x30–0x32 map to the slot group (bit 3), and 0x33–0x3E map to the sequence group (bit 4).
- R7: Any other address below 0x40 is ungrouped and is always writable.
- R8: Addresses 0x40–0xEF and 0xF2–0xFF hold no register. Writes to them give `wr_accepted` = 0, and reads from them return 0.
- R9: `wr_accepted` is 1 in the cycle after an accepted write. It is 0 after a suppressed write and after any cycle with no write.
- R10: `rd_data` shows the content at `rd_addr` combinationally and is never blocked by a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| wr_accepted | output | 1 | Registered: the previous cycle's write landed |

## Verification
A write presented in cycle N updates its register, or a key register, at the edge that ends cycle N. That edge also registers `wr_accepted`, so both results are due one cycle after the stimulus. The bench drives each write on a falling edge and samples `wr_accepted` on the next falling edge. It then sets `rd_addr` to the written address and compares `rd_data` 1 ns later, because the read path has no register. A key write therefore affects only writes issued in later cycles. The reference model applies each write only after its acceptance has been checked.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int STUB_DEPTH = 64;
    localparam int STUB_AW    = $clog2(STUB_DEPTH);

    localparam logic [ADDR_W-1:0] KEY_A_ADDR = 8'hF0;
    localparam logic [ADDR_W-1:0] KEY_B_ADDR = 8'hF1;
    localparam logic [DATA_W-1:0] KEY_MASK   = 8'h59;

    localparam int LBIT_WORK = 6;
    localparam int LBIT_SEQ  = 4;
    localparam int LBIT_SLOT = 3;
    localparam int LBIT_CTL  = 0;

    typedef enum logic [2:0] {
        GRP_FREE,
        GRP_WORK,
        GRP_CTL,
        GRP_SLOT,
        GRP_SEQ,
        GRP_KEY,
        GRP_VOID
    } grp_e;

    function automatic logic grp_lockable(grp_e g);
        return (g == GRP_WORK) || (g == GRP_CTL) || (g == GRP_SLOT) || (g == GRP_SEQ);
    endfunction

    function automatic int unsigned grp_lock_bit(grp_e g);
        case (g)
            GRP_WORK: return LBIT_WORK;
            GRP_SEQ:  return LBIT_SEQ;
            GRP_SLOT: return LBIT_SLOT;
            default:  return LBIT_CTL;
        endcase
    endfunction

endpackage

// File: rtl/grp_decode.sv
module grp_decode
    import cfg_lock_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output grp_e              grp
);

    always_comb begin
        if (addr == KEY_A_ADDR || addr == KEY_B_ADDR) begin
            grp = GRP_KEY;
        end else if (int'(addr) >= STUB_DEPTH) begin
            grp = GRP_VOID;
        end else if (addr >= 8'h10 && addr <= 8'h1F) begin
            grp = GRP_WORK;
        end else if (addr == 8'h25 || addr == 8'h28 || addr == 8'h29 || addr == 8'h2B) begin
            grp = GRP_CTL;
        end else if (addr >= 8'h30 && addr <= 8'h32) begin
            grp = GRP_SLOT;
        end else if (addr >= 8'h33 && addr <= 8'h3E) begin
            grp = GRP_SEQ;
        end else begin
            grp = GRP_FREE;
        end
    end

endmodule

// File: rtl/key_pair.sv
module key_pair
    import cfg_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic              key_sel_b,
    input  logic [DATA_W-1:0] key_wdata,
    output logic [DATA_W-1:0] key_a,
    output logic [DATA_W-1:0] key_b,
    output logic [DATA_W-1:0] lock_vec
);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_we) begin
            if (key_sel_b) st_d.b = st_q.b | (key_wdata & KEY_MASK);
            else           st_d.a = st_q.a | (key_wdata & KEY_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key_a    = st_q.a;
    assign key_b    = st_q.b;
    assign lock_vec = st_q.a & st_q.b;

endmodule

// File: rtl/stub_regfile.sv
module stub_regfile
    import cfg_lock_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [STUB_AW-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [STUB_AW-1:0] raddr,
    output logic [DATA_W-1:0]  rdata
);

    logic [STUB_DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/cfg_wr_guard.sv
module cfg_wr_guard
    import cfg_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_accepted
);

    typedef struct packed {
        logic acc;
    } top_st_t;

    top_st_t st_d, st_q;

    grp_e              wr_grp, rd_grp;
    logic [DATA_W-1:0] key_a_q, key_b_q, lock_vec;
    logic [DATA_W-1:0] stub_rdata;
    logic              allowed, stub_we, key_we;

    grp_decode i_wr_dec (.addr(wr_addr), .grp(wr_grp));
    grp_decode i_rd_dec (.addr(rd_addr), .grp(rd_grp));

    always_comb begin
        case (wr_grp)
            GRP_FREE, GRP_KEY: allowed = 1'b1;
            GRP_VOID:          allowed = 1'b0;
            default:           allowed = ~lock_vec[grp_lock_bit(wr_grp)];
        endcase
        key_we  = wr_en && (wr_grp == GRP_KEY);
        stub_we = wr_en && allowed && (wr_grp != GRP_KEY);
    end

    key_pair i_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_we    (key_we),
        .key_sel_b (wr_addr == KEY_B_ADDR),
        .key_wdata (wr_data),
        .key_a     (key_a_q),
        .key_b     (key_b_q),
        .lock_vec  (lock_vec)
    );

    stub_regfile i_stub (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (stub_we),
        .waddr (wr_addr[STUB_AW-1:0]),
        .wdata (wr_data),
        .raddr (rd_addr[STUB_AW-1:0]),
        .rdata (stub_rdata)
    );

    always_comb begin
        case (rd_grp)
            GRP_KEY:  rd_data = (rd_addr == KEY_B_ADDR) ? key_b_q : key_a_q;
            GRP_VOID: rd_data = '0;
            default:  rd_data = stub_rdata;
        endcase
    end

    always_comb begin
        st_d.acc = wr_en && allowed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_accepted = st_q.acc;

endmodule

// File: rtl/cfg_wr_guard_chk.sv
module cfg_wr_guard_chk
    import cfg_lock_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input grp_e              wr_grp,
    input logic [DATA_W-1:0] lock_vec,
    input logic [DATA_W-1:0] key_a,
    input logic [DATA_W-1:0] key_b,
    input logic              wr_accepted
);

    // R3
    key_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(key_a) & ~key_a) == '0) && (($past(key_b) & ~key_b) == '0));

    // R2
    key_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((key_a | key_b) & ~KEY_MASK) == '0);

    // R5
    locked_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp_lockable(wr_grp) && lock_vec[grp_lock_bit(wr_grp)]) |=> !wr_accepted);

    // R8
    void_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_grp == GRP_VOID) |=> !wr_accepted);

    // R9
    idle_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_accepted);

endmodule

bind cfg_wr_guard cfg_wr_guard_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_grp      (wr_grp),
    .lock_vec    (lock_vec),
    .key_a       (key_a_q),
    .key_b       (key_b_q),
    .wr_accepted (wr_accepted)
);

// File: tb/test_cfg_wr_guard.sv
`timescale 1ns/1ps
module test_cfg_wr_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_accepted;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_mem [64];
    logic [7:0] m_ka = '0;
    logic [7:0] m_kb = '0;

    always #2.5 clk = ~clk;

    cfg_wr_guard i_cfg_wr_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_accepted(wr_accepted)
    );

    // -1 free, -2 key, -3 void, else lock bit
    function automatic int grp_bit(logic [7:0] a);
        if (a == 8'hF0 || a == 8'hF1) return -2;
        if (a >= 8'h40) return -3;
        if (a >= 8'h10 && a <= 8'h1F) return 6;
        if (a == 8'h25 || a == 8'h28 || a == 8'h29 || a == 8'h2B) return 0;
        if (a >= 8'h30 && a <= 8'h32) return 3;
        if (a >= 8'h33 && a <= 8'h3E) return 4;
        return -1;
    endfunction

    function automatic logic exp_accept(logic [7:0] a);
        int b = grp_bit(a);
        if (b == -1 || b == -2) return 1'b1;
        if (b == -3) return 1'b0;
        return !(m_ka[b] && m_kb[b]);
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        if (a == 8'hF0) return m_ka;
        if (a == 8'hF1) return m_kb;
        if (a >= 8'h40) return 8'h00;
        return m_mem[a[5:0]];
    endfunction

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic read_chk(input logic [7:0] a, input string req);
        logic [7:0] e;
        rd_addr = a;
        #1;
        e = exp_read(a);
        check(rd_data == e, req, rd_data, e);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string req);
        logic ea;
        ea = exp_accept(a);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(wr_accepted == ea, req, {7'd0, wr_accepted}, {7'd0, ea});
        if (a == 8'hF0) m_ka = m_ka | (d & 8'h59);
        else if (a == 8'hF1) m_kb = m_kb | (d & 8'h59);
        else if (ea) m_mem[a[5:0]] = d;
        read_chk(a, req);
    endtask

    function automatic logic [7:0] pick_addr(int unsigned r);
        case (r % 8)
            0: return 8'h10 + 8'(($urandom % 16));
            1: begin
                case ($urandom % 4)
                    0: return 8'h25;
                    1: return 8'h28;
                    2: return 8'h29;
                    default: return 8'h2B;
                endcase
            end
            2: return 8'h30 + 8'(($urandom % 3));
            3: return 8'h33 + 8'(($urandom % 12));
            4: return 8'h00 + 8'(($urandom % 16));
            5: return 8'h40 + 8'(($urandom % 176));
            6: return 8'hF2 + 8'(($urandom % 14));
            default: return 8'h3F;
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(wr_accepted == 1'b0, "R1", {7'd0, wr_accepted}, 8'h00);
        read_chk(8'hF0, "R1");
        read_chk(8'hF1, "R1");
        read_chk(8'h31, "R1");
        read_chk(8'h12, "R1");

        // R9 idle cycle gives no accept
        @(negedge clk);
        check(wr_accepted == 1'b0, "R9", {7'd0, wr_accepted}, 8'h00);

        // R6 / R7 open writes
        do_write(8'h30, 8'hA5, "R6");
        do_write(8'h20, 8'h3C, "R7");
        do_write(8'h3F, 8'h11, "R7");

        // R2 masked set
        do_write(8'hF0, 8'hFF, "R2");
        // R4 one key only: slot group still writable
        do_write(8'h31, 8'h5A, "R4");
        // lock slot group via key B bit 3
        do_write(8'hF1, 8'h08, "R4");
        do_write(8'h30, 8'h00, "R5");
        do_write(8'h32, 8'h77, "R5");
        // R10 read of locked register still returns content
        read_chk(8'h30, "R10");
        // R4 sequence group: only key A bit 4, still open
        do_write(8'h33, 8'h66, "R4");
        // R3 writing zero keeps bits
        do_write(8'hF0, 8'h00, "R3");
        do_write(8'hF1, 8'h00, "R3");
        do_write(8'h31, 8'hEE, "R3");
        // R8 void space
        do_write(8'h55, 8'h99, "R8");
        do_write(8'hF7, 8'h99, "R8");
        read_chk(8'h80, "R8");

        // R6 lock control group
        do_write(8'hF1, 8'h01, "R6");
        do_write(8'h28, 8'h42, "R6");
        do_write(8'h26, 8'h42, "R7");

        // random phase
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            if ($urandom % 40 == 0)
                a = ($urandom % 2 == 0) ? 8'hF0 : 8'hF1;
            else
                a = pick_addr($urandom);
            if (a == 8'hF0 || a == 8'hF1)
                do_write(a, 8'(1 << ($urandom % 8)), "R2");
            else
                do_write(a, 8'($urandom), "R5");
            if ($urandom % 5 == 0) begin
                @(negedge clk);
                check(wr_accepted == 1'b0, "R9", {7'd0, wr_accepted}, 8'h00);
            end
        end

        // R10 sweep reads
        for (int a = 0; a < 256; a += 7) read_chk(8'(a), "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule